// File: doc/BRIEF.md
# SDRAM Data Width Adapter

The adapter sits between a 32-bit application data port and an SDRAM data path whose width is picked at run time: 32, 16 or 8 bits. On the write side the transfer engine pulls beats from it. Each application word, together with its four active-low byte enables, is cut into one, two or four beats. The least-significant slice goes first. Each beat leaves on the low lanes of the SDRAM-side bus, and the lanes it does not use are driven to zero data with their enables off. The application is asked for its next word in the same cycle that the engine takes the final beat of the current word.

On the read side the engine delivers beats with a strobe. The adapter places each beat in its byte position inside an accumulator. When a word is complete, it presents the word on the application port one cycle later with a valid pulse. A start pulse on either side puts the beat index back at the first slice. A last pulse closes the word early and is passed on to the application as a burst-last flag.

Top module: `bsc_width_adapter`

## Requirements
- R1: `width_sel_i` selects the beats per application word: 2'b00 gives 1 beat (32-bit SDRAM), 2'b01 gives 2 beats (16-bit), and 2'b10 or 2'b11 give 4 beats (8-bit).
- R2: The write beat with index k carries application bytes k*L to k*L+L-1 on SDRAM bytes 0 to L-1 of `sdr_wr_data_o` (L = 4 / beats; byte n is bits 8n+7:8n). Beat 0 holds the least-significant bytes. SDRAM bytes L to 3 read zero. This output is combinational from the current word and beat index.
- R3: `sdr_wr_be_n_o` bit j carries the application enable bit k*L+j for j < L, and 1 (disabled) for unused lanes.
- R4: `app_wr_next_o` is high in exactly the cycles where `wr_next_i` is high and the beat taken is either the final beat of the word (index beats-1) or is flagged by `wr_last_i`. In both cases the write beat index returns to 0. Any other `wr_next_i` advances the index by one.
- R5: `app_wr_last_o` is high in exactly the cycles where `wr_next_i` and `wr_last_i` are both high.
- R6: `wr_start_i` forces the write beat index to 0 for its own cycle, including when `wr_next_i` is high in that cycle, and leaves it at 0 when no beat is taken.
- R7: Each `rd_ok_i` beat with index k is written into application bytes k*L to k*L+L-1 from SDRAM bytes 0 to L-1. When the beat is the final one of the word, or `rd_last_i` is high, the packed word appears on `app_rd_data_o` with `app_rd_valid_o` high for one cycle, starting in the cycle after that beat. `app_rd_data_o` keeps its value until the next completed word.
- R8: `app_rd_last_o` is high together with `app_rd_valid_o` for a word closed by a beat that carried `rd_last_i`, and is low at all other times.
- R9: `rd_start_i` discards any partly collected word and places a beat in the same cycle at index 0. Bytes that a word closed early by `rd_last_i` never received read as zero.
- R10: While `rst_ni` is low, `app_rd_data_o` is zero, `app_rd_valid_o` and `app_rd_last_o` are low, and both beat indices are 0.
- R11: The read and write paths are independent: activity in the same cycle on both sides gives the same results as the same activity on each side alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| width_sel_i | input | 2 | SDRAM width select: 00 = 32, 01 = 16, 1x = 8 bits |
| app_wr_data_i | input | 32 | Current application write word |
| app_wr_be_n_i | input | 4 | Active-low byte enables of the current word |
| app_wr_next_o | output | 1 | Application should present its next write word |
| app_wr_last_o | output | 1 | Final write transfer of the burst |
| app_rd_data_o | output | 32 | Packed read word |
| app_rd_valid_o | output | 1 | Read word valid |
| app_rd_last_o | output | 1 | Final read word of the burst |
| wr_start_i | input | 1 | Write burst start pulse from the transfer engine |
| wr_next_i | input | 1 | Engine takes the current write beat |
| wr_last_i | input | 1 | The beat taken is the last of the burst |
| sdr_wr_data_o | output | 32 | Write beat toward SDRAM, low lanes used |
| sdr_wr_be_n_o | output | 4 | Active-low enables of the write beat |
| rd_start_i | input | 1 | Read burst start pulse from the transfer engine |
| rd_ok_i | input | 1 | Read beat valid on `sdr_rd_data_i` |
| rd_last_i | input | 1 | The read beat is the last of the burst |
| sdr_rd_data_i | input | 32 | Read beat from SDRAM, low lanes used |

## Verification
The coincidence that matters is a start pulse that lands in the same cycle as a beat strobe. The start must win over the running index, so the beat goes to slice 0 while a partly built word is dropped. Directed steps raise `wr_start_i` with `wr_next_i`, and `rd_start_i` with `rd_ok_i`, in the middle of a word in 8-bit mode. Random segments also raise them together. The bench model computes the slice position and the packed word for each cycle, and every clock is compared against it: write slice data, enables and strobes in the same cycle, and read word and flags one cycle later.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

  typedef enum logic [1:0] {
    SH_WORD = 2'd0,
    SH_HALF = 2'd1,
    SH_BYTE = 2'd2
  } beat_shift_e;

  // 00 -> 1 beat, 01 -> 2 beats, 1x -> 4 beats
  function automatic beat_shift_e sel_to_shift(input logic [1:0] sel);
    if (sel[1]) return SH_BYTE;
    if (sel[0]) return SH_HALF;
    return SH_WORD;
  endfunction

endpackage

// File: rtl/bsc_mode_dec.sv
module bsc_mode_dec
  import bsc_pkg::*;
#(
  parameter int CW = 2
) (
  input  logic [1:0]    width_sel_i,
  output logic [1:0]    shift_o,
  output logic [CW-1:0] last_idx_o
);

  beat_shift_e sh;

  always_comb begin
    sh         = sel_to_shift(width_sel_i);
    shift_o    = sh;
    last_idx_o = CW'((1 << sh) - 1);
  end

endmodule

// File: rtl/bsc_wr_split.sv
module bsc_wr_split #(
  parameter int BYTES = 4,
  parameter int BW    = 8,
  localparam int DW   = BYTES * BW,
  localparam int CW   = $clog2(BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       shift_i,
  input  logic [CW-1:0]    last_idx_i,
  input  logic [DW-1:0]    word_i,
  input  logic [BYTES-1:0] be_n_i,
  input  logic             start_i,
  input  logic             next_i,
  input  logic             last_i,
  output logic [DW-1:0]    beat_o,
  output logic [BYTES-1:0] beat_be_n_o,
  output logic             word_done_o,
  output logic             burst_last_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] idx;
  int            lanes;

  always_comb begin
    idx         = start_i ? '0 : cnt_q;
    lanes       = BYTES >> shift_i;
    beat_o      = '0;
    beat_be_n_o = '1;
    for (int j = 0; j < BYTES; j++) begin
      if (j < lanes) begin
        beat_o[j*BW +: BW] = word_i[(int'(idx) * lanes + j)*BW +: BW];
        beat_be_n_o[j]     = be_n_i[int'(idx) * lanes + j];
      end
    end
    word_done_o  = next_i && ((idx == last_idx_i) || last_i);
    burst_last_o = next_i && last_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (next_i) begin
      cnt_q <= word_done_o ? '0 : idx + CW'(1);
    end else if (start_i) begin
      cnt_q <= '0;
    end
  end

endmodule

// File: rtl/bsc_rd_pack.sv
module bsc_rd_pack #(
  parameter int BYTES = 4,
  parameter int BW    = 8,
  localparam int DW   = BYTES * BW,
  localparam int CW   = $clog2(BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    shift_i,
  input  logic [CW-1:0] last_idx_i,
  input  logic          start_i,
  input  logic          ok_i,
  input  logic          last_i,
  input  logic [DW-1:0] beat_i,
  output logic [DW-1:0] word_o,
  output logic          valid_o,
  output logic          last_o
);

  logic [CW-1:0] cnt_q;
  logic [DW-1:0] acc_q;
  logic [CW-1:0] idx;
  logic [DW-1:0] ins;
  logic          done;
  int            lanes;

  always_comb begin
    idx   = start_i ? '0 : cnt_q;
    lanes = BYTES >> shift_i;
    ins   = start_i ? '0 : acc_q;
    for (int j = 0; j < BYTES; j++) begin
      if (j < lanes) ins[(int'(idx) * lanes + j)*BW +: BW] = beat_i[j*BW +: BW];
    end
    done = ok_i && ((idx == last_idx_i) || last_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      acc_q   <= '0;
      word_o  <= '0;
      valid_o <= 1'b0;
      last_o  <= 1'b0;
    end else begin
      valid_o <= done;
      last_o  <= done && last_i;
      if (done) begin
        word_o <= ins;
        acc_q  <= '0;
        cnt_q  <= '0;
      end else if (ok_i) begin
        acc_q <= ins;
        cnt_q <= idx + CW'(1);
      end else if (start_i) begin
        acc_q <= '0;
        cnt_q <= '0;
      end
    end
  end

endmodule

// File: rtl/bsc_width_adapter.sv
module bsc_width_adapter #(
  parameter int BYTES = 4,
  parameter int BW    = 8,
  localparam int DW   = BYTES * BW,
  localparam int CW   = $clog2(BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       width_sel_i,
  input  logic [DW-1:0]    app_wr_data_i,
  input  logic [BYTES-1:0] app_wr_be_n_i,
  output logic             app_wr_next_o,
  output logic             app_wr_last_o,
  output logic [DW-1:0]    app_rd_data_o,
  output logic             app_rd_valid_o,
  output logic             app_rd_last_o,
  input  logic             wr_start_i,
  input  logic             wr_next_i,
  input  logic             wr_last_i,
  output logic [DW-1:0]    sdr_wr_data_o,
  output logic [BYTES-1:0] sdr_wr_be_n_o,
  input  logic             rd_start_i,
  input  logic             rd_ok_i,
  input  logic             rd_last_i,
  input  logic [DW-1:0]    sdr_rd_data_i
);

  logic [1:0]    shift;
  logic [CW-1:0] last_idx;

  bsc_mode_dec #(.CW(CW)) u_dec (
    .width_sel_i (width_sel_i),
    .shift_o     (shift),
    .last_idx_o  (last_idx)
  );

  bsc_wr_split #(.BYTES(BYTES), .BW(BW)) u_wr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .shift_i      (shift),
    .last_idx_i   (last_idx),
    .word_i       (app_wr_data_i),
    .be_n_i       (app_wr_be_n_i),
    .start_i      (wr_start_i),
    .next_i       (wr_next_i),
    .last_i       (wr_last_i),
    .beat_o       (sdr_wr_data_o),
    .beat_be_n_o  (sdr_wr_be_n_o),
    .word_done_o  (app_wr_next_o),
    .burst_last_o (app_wr_last_o)
  );

  bsc_rd_pack #(.BYTES(BYTES), .BW(BW)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_i    (shift),
    .last_idx_i (last_idx),
    .start_i    (rd_start_i),
    .ok_i       (rd_ok_i),
    .last_i     (rd_last_i),
    .beat_i     (sdr_rd_data_i),
    .word_o     (app_rd_data_o),
    .valid_o    (app_rd_valid_o),
    .last_o     (app_rd_last_o)
  );

endmodule

// File: rtl/bsc_checker.sv
module bsc_checker #(
  parameter int BYTES = 4,
  parameter int BW    = 8,
  localparam int DW   = BYTES * BW
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       width_sel_i,
  input logic             wr_next_i,
  input logic             rd_ok_i,
  input logic             app_wr_next_o,
  input logic             app_wr_last_o,
  input logic             app_rd_valid_o,
  input logic             app_rd_last_o,
  input logic [DW-1:0]    sdr_wr_data_o,
  input logic [BYTES-1:0] sdr_wr_be_n_o
);

  AST_WORD_MODE_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (width_sel_i == 2'b00 && wr_next_i) |-> app_wr_next_o); // R1
  AST_WORD_MODE_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (width_sel_i == 2'b00 && rd_ok_i) |=> app_rd_valid_o); // R1
  AST_HALF_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (width_sel_i == 2'b01) |-> (sdr_wr_data_o[DW-1:DW/2] == '0)); // R2
  AST_BYTE_BE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    width_sel_i[1] |-> (sdr_wr_be_n_o[BYTES-1:1] == '1)); // R3
  AST_NEXT_NEEDS_PULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    app_wr_next_o |-> wr_next_i); // R4
  AST_WR_LAST_WITH_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    app_wr_last_o |-> app_wr_next_o); // R5
  AST_RD_VALID_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    app_rd_valid_o |-> $past(rd_ok_i)); // R7
  AST_RD_LAST_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    app_rd_last_o |-> app_rd_valid_o); // R8

endmodule

bind bsc_width_adapter bsc_checker #(.BYTES(BYTES), .BW(BW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .width_sel_i    (width_sel_i),
  .wr_next_i      (wr_next_i),
  .rd_ok_i        (rd_ok_i),
  .app_wr_next_o  (app_wr_next_o),
  .app_wr_last_o  (app_wr_last_o),
  .app_rd_valid_o (app_rd_valid_o),
  .app_rd_last_o  (app_rd_last_o),
  .sdr_wr_data_o  (sdr_wr_data_o),
  .sdr_wr_be_n_o  (sdr_wr_be_n_o)
);

// File: tb/sim_bsc_width_adapter.sv
module sim_bsc_width_adapter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  width_sel = 2'b00;
  logic [31:0] app_wr_data = '0;
  logic [3:0]  app_wr_be_n = '0;
  logic        wr_start = 0, wr_next = 0, wr_last = 0;
  logic        rd_start = 0, rd_ok = 0, rd_last = 0;
  logic [31:0] sdr_rd_data = '0;
  logic        app_wr_next, app_wr_last, app_rd_valid, app_rd_last;
  logic [31:0] app_rd_data, sdr_wr_data;
  logic [3:0]  sdr_wr_be_n;

  int checks = 0, errors = 0;
  bit finished = 0;
  string phase = "reset";

  // reference model state
  int          wcnt = 0, rcnt = 0;
  logic [31:0] racc = '0, exp_rdata = '0;
  bit          exp_rv = 0, exp_rl = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bsc_width_adapter u0 (
    .clk_i(clk), .rst_ni(rst_n), .width_sel_i(width_sel),
    .app_wr_data_i(app_wr_data), .app_wr_be_n_i(app_wr_be_n),
    .app_wr_next_o(app_wr_next), .app_wr_last_o(app_wr_last),
    .app_rd_data_o(app_rd_data), .app_rd_valid_o(app_rd_valid), .app_rd_last_o(app_rd_last),
    .wr_start_i(wr_start), .wr_next_i(wr_next), .wr_last_i(wr_last),
    .sdr_wr_data_o(sdr_wr_data), .sdr_wr_be_n_o(sdr_wr_be_n),
    .rd_start_i(rd_start), .rd_ok_i(rd_ok), .rd_last_i(rd_last), .sdr_rd_data_i(sdr_rd_data)
  );

  function automatic int beats_of(logic [1:0] s);
    if (s[1]) return 4;
    if (s[0]) return 2;
    return 1;
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s] %s act=%h exp=%h", req, phase, what, act, exp);
    end
  endtask

  // compare this cycle, then advance the model over one clock edge
  task automatic cyc();
    int b, l, idx, ridx;
    logic [31:0] ed;
    logic [3:0]  eb;
    bit en, el, done;
    #1;
    b = beats_of(width_sel); l = 4 / b;
    idx = wr_start ? 0 : wcnt;
    ed = '0; eb = '1;
    for (int j = 0; j < l; j++) begin
      ed[j*8 +: 8] = app_wr_data[(idx*l + j)*8 +: 8];
      eb[j] = app_wr_be_n[idx*l + j];
    end
    en = wr_next && (idx == b-1 || wr_last);
    el = wr_next && wr_last;
    check(sdr_wr_data == ed, "R2", "wr slice data", sdr_wr_data, ed);
    check(sdr_wr_be_n == eb, "R3", "wr slice be_n", 32'(sdr_wr_be_n), 32'(eb));
    check(app_wr_next == en, "R4", "app_wr_next", 32'(app_wr_next), 32'(en));
    check(app_wr_last == el, "R5", "app_wr_last", 32'(app_wr_last), 32'(el));
    check(app_rd_valid == exp_rv, "R7", "app_rd_valid", 32'(app_rd_valid), 32'(exp_rv));
    check(app_rd_data == exp_rdata, "R7", "app_rd_data", app_rd_data, exp_rdata);
    check(app_rd_last == exp_rl, "R8", "app_rd_last", 32'(app_rd_last), 32'(exp_rl));
    @(posedge clk);
    if (wr_next) wcnt = en ? 0 : idx + 1;
    else if (wr_start) wcnt = 0;
    ridx = rd_start ? 0 : rcnt;
    if (rd_start) racc = '0;
    exp_rv = 0; exp_rl = 0;
    if (rd_ok) begin
      for (int j = 0; j < l; j++) racc[(ridx*l + j)*8 +: 8] = sdr_rd_data[j*8 +: 8];
      done = (ridx == b-1) || rd_last;
      if (done) begin
        exp_rdata = racc; exp_rv = 1; exp_rl = rd_last; racc = '0; rcnt = 0;
      end else rcnt = ridx + 1;
    end else if (rd_start) rcnt = 0;
    @(negedge clk);
  endtask

  task automatic drv(bit ws, bit wn, bit wl, bit rs, bit ro, bit rl);
    wr_start = ws; wr_next = wn; wr_last = wl;
    rd_start = rs; rd_ok = ro; rd_last = rl;
    cyc();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    repeat (2) @(negedge clk);
    check(app_rd_data == 0, "R10", "rd data in reset", app_rd_data, 0);
    check(app_rd_valid == 0, "R10", "rd valid in reset", 32'(app_rd_valid), 0);
    check(app_rd_last == 0, "R10", "rd last in reset", 32'(app_rd_last), 0);
    rst_n = 1'b1;
    drv(0,0,0,0,0,0);

    // R1: word mode, one beat per word
    phase = "R1 word mode";
    width_sel = 2'b00;
    app_wr_data = 32'hA1B2C3D4; app_wr_be_n = 4'b0110; sdr_rd_data = 32'h11223344;
    drv(1,1,0,1,1,0);
    app_wr_data = 32'h55667788; sdr_rd_data = 32'h99AABBCC;
    drv(0,1,1,0,1,1);
    drv(0,0,0,0,0,0);

    // R2 R3: half mode, two beats per word
    phase = "R2 R3 half mode";
    width_sel = 2'b01;
    app_wr_data = 32'hCAFEBABE; app_wr_be_n = 4'b1001;
    drv(1,1,0,0,0,0);
    drv(0,0,0,0,0,0);
    drv(0,1,0,0,0,0);
    app_wr_data = 32'h0BADF00D; app_wr_be_n = 4'b0011;
    drv(0,1,0,0,0,0);
    drv(0,1,1,0,0,0);

    // R6: write start restarts mid-word, 8-bit mode
    phase = "R6 write restart";
    width_sel = 2'b10;
    app_wr_data = 32'h44332211; app_wr_be_n = 4'b1010;
    drv(1,1,0,0,0,0);
    drv(0,1,0,0,0,0);
    drv(1,1,0,0,0,0);
    drv(0,1,0,0,0,0);
    drv(1,0,0,0,0,0);
    drv(0,1,0,0,0,0);

    // R4: early last closes a word after two byte beats
    phase = "R4 early write last";
    width_sel = 2'b11;
    drv(0,1,0,0,0,0);
    drv(0,1,1,0,0,0);
    drv(0,1,0,0,0,0);

    // R9: read restart and early last, 8-bit mode
    phase = "R9 read restart";
    width_sel = 2'b10;
    sdr_rd_data = 32'h000000AA; drv(0,0,0,1,1,0);
    sdr_rd_data = 32'h000000BB; drv(0,0,0,0,1,0);
    sdr_rd_data = 32'h00000011; drv(0,0,0,1,1,0);
    sdr_rd_data = 32'h00000022; drv(0,0,0,0,1,0);
    sdr_rd_data = 32'h00000033; drv(0,0,0,0,1,0);
    sdr_rd_data = 32'h00000044; drv(0,0,0,0,1,0);
    sdr_rd_data = 32'h00000077; drv(0,0,0,0,1,1);
    drv(0,0,0,1,0,0);
    drv(0,0,0,0,0,0);

    // R11: both sides active together
    phase = "R11 concurrent";
    width_sel = 2'b01;
    app_wr_data = 32'h13579BDF; sdr_rd_data = 32'h0000BEEF;
    drv(1,1,0,1,1,0);
    sdr_rd_data = 32'h0000DEAD;
    drv(0,1,1,0,1,1);
    drv(0,0,0,0,0,0);

    // random segments, width changes only with start pulses
    phase = "R11 random";
    for (int s = 0; s < 40; s++) begin
      width_sel = 2'($urandom_range(0, 3));
      app_wr_data = $urandom; app_wr_be_n = 4'($urandom);
      sdr_rd_data = $urandom;
      drv(1, 1'($urandom_range(0, 1)), 0, 1, 1'($urandom_range(0, 1)), 0);
      for (int c = 0; c < 40; c++) begin
        app_wr_data = $urandom; app_wr_be_n = 4'($urandom); sdr_rd_data = $urandom;
        drv($urandom_range(0, 19) == 0, $urandom_range(0, 9) < 6, $urandom_range(0, 9) < 2,
            $urandom_range(0, 19) == 0, $urandom_range(0, 9) < 6, $urandom_range(0, 9) < 2);
      end
    end
    drv(0,0,0,0,0,0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule